// File: doc/BRIEF.md
# Sampling Converter Host Control and Three-State Bus Interface

This block sits between a host bus and the conversion sequencer of a sampling converter. The host drives three control levels, an active-low chip select, a read/convert line and a high-byte enable. All three are brought into the core clock through two-stage synchronisers. A conversion is launched only by a qualified falling edge of the read/convert line. The block then sends a one-cycle start strobe to the sequencer and drops its busy output until the sequencer answers with a done pulse carrying the 12-bit result. That result is latched and presented on a 12-line data bus. Each line has its own output-enable bit, so a pad ring or a bench can see the high-impedance state line by line.

Two host styles are supported. In convert mode the host pulses read/convert low, and the data appears once busy rises again. In read mode the host pulses read/convert high, which shows the previous result. The falling edge at the end of that pulse starts the next conversion. For an 8-bit host bus, the high-byte enable folds the top four result bits onto the four lowest lines and forces the four lines above them low.

The result path is a one-shot transfer with done acting as the valid. There is no ready: the block only waits for done while a conversion is running, and it accepts the result in that same cycle. There is never back-pressure toward the sequencer. The host reads on levels, not by handshake.

Top module: `conv_host_ctrl`

## Requirements
- R1: After reset, busy_o is 1, start_o is 0 and every bit of bus_oe_o is 0.
- R2: start_o pulses for exactly one cycle, and busy_o falls on the same edge. This happens only for a falling edge of the synchronised rdconv_i while the synchronised sel_n_i is 0, the synchronised hibyte_i is 0 and busy_o is 1. No other combination starts a conversion.
- R3: While busy_o is 0, no transition on sel_n_i, rdconv_i or hibyte_i starts a conversion or ends the running one. busy_o stays 0 until done_i is seen.
- R4: A done_i pulse while busy_o is 0 latches result_i and sets busy_o to 1 on the next edge. A done_i pulse while busy_o is 1 is ignored, and the latched result is unchanged.
- R5: bus_oe_o is all ones exactly when the synchronised rdconv_i is 1, busy_o is 1 and the synchronised sel_n_i is 0. Otherwise it is all zeros, and in particular it is all zeros throughout a conversion.
- R6: While the synchronised sel_n_i is 1, bus_oe_o is all zeros whatever the other inputs are.
- R7: With hibyte_i at 0, bus_o equals the latched result: bit 11 on line 11 down to bit 0 on line 0.
- R8: With hibyte_i at 1, result bits 11..8 appear on lines 3..0 (bit 11 on line 3) and also remain on lines 11..8. Lines 7..4 are driven 0.
- R9: An input change is visible at the outputs after two rising edges, the synchroniser depth. start_o is first seen high after the third rising edge following a falling edge of rdconv_i, with the other inputs already settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Chip select, active low, asynchronous to clk |
| rdconv_i | input | 1 | Read/convert line, asynchronous to clk |
| hibyte_i | input | 1 | High-byte enable, asynchronous to clk |
| busy_o | output | 1 | 1 when idle, 0 while a conversion runs |
| start_o | output | 1 | One-cycle conversion start strobe to the sequencer |
| done_i | input | 1 | Sequencer done pulse; result_i is valid with it |
| result_i | input | 12 | Conversion result from the sequencer |
| bus_o | output | 12 | Data bus value |
| bus_oe_o | output | 12 | Per-line output enable for bus_o |

## Verification
The hardest situation to reach is host activity that arrives while a conversion is running. Falling read/convert edges with a valid select and byte enable must be swallowed, not queued. Reaching this needs the sequencer held busy for a long time. The bench therefore replaces the sequencer with a model that can be switched to manual mode, holds busy low and hammers the control lines before it releases done. Random single-signal steps then cover the mixes of mode, select and byte enable, each settled past the synchroniser.

// File: rtl/conv_host_pkg.sv
package conv_host_pkg;

  typedef struct packed {
    logic sel_n;
    logic rdconv;
    logic hibyte;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{sel_n: 1'b1, rdconv: 1'b0, hibyte: 1'b0};

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } conv_state_e;

endpackage

// File: rtl/chi_sync.sv
module chi_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/chi_seq.sv
module chi_seq
  import conv_host_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fall,
  input  logic          sel_n_s,
  input  logic          hib_s,
  input  logic          done_i,
  input  logic [DW-1:0] result_i,
  output logic          start_o,
  output logic          idle_o,
  output logic [DW-1:0] res_o
);

  conv_state_e state_q;
  logic        go;

  // a launch needs the edge, a selected device and word mode
  assign go = rd_fall & ~sel_n_s & ~hib_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_o <= 1'b0;
      res_o   <= '0;
    end else begin
      start_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q <= ST_CONV;
            start_o <= 1'b1;
          end
        end
        ST_CONV: begin
          // host inputs are not looked at here
          if (done_i) begin
            state_q <= ST_IDLE;
            res_o   <= result_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == ST_IDLE);

endmodule

// File: rtl/chi_steer.sv
module chi_steer #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] res,
  input  logic          rd_s,
  input  logic          sel_n_s,
  input  logic          hib_s,
  input  logic          idle,
  output logic [DW-1:0] bus_o,
  output logic [DW-1:0] oe_o
);

  localparam int HI_W = DW - 8;

  logic enable;

  assign enable = rd_s & idle & ~sel_n_s;
  assign oe_o   = {DW{enable}};

  always_comb begin
    if (hib_s) begin
      bus_o            = '0;
      bus_o[DW-1:8]    = res[DW-1:8];
      bus_o[HI_W-1:0]  = res[DW-1:8];
    end else begin
      bus_o = res;
    end
  end

endmodule

// File: rtl/conv_host_ctrl.sv
module conv_host_ctrl
  import conv_host_pkg::*;
#(
  parameter int DW          = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n_i,
  input  logic          rdconv_i,
  input  logic          hibyte_i,
  output logic          busy_o,
  output logic          start_o,
  input  logic          done_i,
  input  logic [DW-1:0] result_i,
  output logic [DW-1:0] bus_o,
  output logic [DW-1:0] bus_oe_o
);

  localparam int CW = $bits(ctl_t);

  ctl_t          ctl_raw;
  ctl_t          ctl_s;
  logic          sel_n_s;
  logic          rd_s;
  logic          hib_s;
  logic          rd_q;
  logic          rd_fall;
  logic          idle;
  logic [DW-1:0] res_q;

  assign ctl_raw = '{sel_n: sel_n_i, rdconv: rdconv_i, hibyte: hibyte_i};

  chi_sync #(
    .STAGES (SYNC_STAGES),
    .W      (CW),
    .RST_VAL(CTL_RESET)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ctl_raw),
    .q    (ctl_s)
  );

  assign sel_n_s = ctl_s.sel_n;
  assign rd_s    = ctl_s.rdconv;
  assign hib_s   = ctl_s.hibyte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_s;
  end

  assign rd_fall = rd_q & ~rd_s;

  chi_seq #(.DW(DW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_fall (rd_fall),
    .sel_n_s (sel_n_s),
    .hib_s   (hib_s),
    .done_i  (done_i),
    .result_i(result_i),
    .start_o (start_o),
    .idle_o  (idle),
    .res_o   (res_q)
  );

  chi_steer #(.DW(DW)) u_steer (
    .res    (res_q),
    .rd_s   (rd_s),
    .sel_n_s(sel_n_s),
    .hib_s  (hib_s),
    .idle   (idle),
    .bus_o  (bus_o),
    .oe_o   (bus_oe_o)
  );

  assign busy_o = idle;

endmodule

// File: rtl/conv_host_ctrl_chk.sv
module conv_host_ctrl_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_o,
  input logic          busy_o,
  input logic          done_i,
  input logic [DW-1:0] bus_o,
  input logic [DW-1:0] bus_oe_o,
  input logic          sel_n_s,
  input logic          hib_s
);

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (!busy_o && $past(busy_o))); // R2

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R2

  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_i) |=> (!busy_o && !start_o)); // R3

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && done_i) |=> busy_o); // R4

  AST_QUIET_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (bus_oe_o == '0)); // R5

  AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bus_oe_o) == 0) || ($countones(bus_oe_o) == DW)); // R5

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |-> (bus_oe_o == '0)); // R6

  AST_BYTE_GAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hib_s |-> (bus_o[7:DW-8] == '0)); // R8

endmodule

bind conv_host_ctrl conv_host_ctrl_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_o (start_o),
  .busy_o  (busy_o),
  .done_i  (done_i),
  .bus_o   (bus_o),
  .bus_oe_o(bus_oe_o),
  .sel_n_s (sel_n_s),
  .hib_s   (hib_s)
);

// File: tb/tb_conv_host_ctrl.sv
module tb_conv_host_ctrl;

  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_n_i = 1'b1;
  logic          rdconv_i = 1'b1;
  logic          hibyte_i = 1'b0;
  logic          done_i = 1'b0;
  logic [DW-1:0] result_i = '0;
  logic          busy_o;
  logic          start_o;
  logic [DW-1:0] bus_o;
  logic [DW-1:0] bus_oe_o;

  int            checks = 0;
  int            errors = 0;
  int            starts_seen = 0;
  int            exp_starts = 0;
  bit            auto_eng = 1'b0;
  int            conv_len = 5;
  logic [DW-1:0] exp_res = '0;

  always #10 clk = ~clk;

  conv_host_ctrl #(.DW(DW)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n_i (sel_n_i),
    .rdconv_i(rdconv_i),
    .hibyte_i(hibyte_i),
    .busy_o  (busy_o),
    .start_o (start_o),
    .done_i  (done_i),
    .result_i(result_i),
    .bus_o   (bus_o),
    .bus_oe_o(bus_oe_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_bus(input logic [DW-1:0] r, input logic hb);
    logic [DW-1:0] w;
    if (hb) begin
      w = '0;
      w[11:8] = r[11:8];
      w[3:0]  = r[11:8];
    end else begin
      w = r;
    end
    return w;
  endfunction

  function automatic logic [DW-1:0] exp_oe(input logic rc, input logic sel_n);
    return (rc && !sel_n) ? {DW{1'b1}} : '0;
  endfunction

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done(input logic [DW-1:0] v);
    result_i = v;
    done_i   = 1'b1;
    @(negedge clk);
    done_i   = 1'b0;
  endtask

  // sequencer model: counts starts, answers automatically when enabled
  initial begin
    forever begin
      @(negedge clk);
      if (start_o) begin
        starts_seen++;
        if (auto_eng) begin
          logic [DW-1:0] v;
          repeat (conv_len - 1) @(negedge clk);
          v = DW'($urandom);
          exp_res  = v;
          result_i = v;
          done_i   = 1'b1;
          @(negedge clk);
          done_i   = 1'b0;
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic cur_sel, cur_rc, cur_hib;
    void'($urandom(32'd20240611));
    waitn(4);
    rst_n = 1'b1;
    waitn(3);

    // R1 reset state
    chk("R1 busy", busy_o, 1);
    chk("R1 start", start_o, 0);
    chk("R1 oe", bus_oe_o, 0);

    // R5 / R7 idle read of reset result
    sel_n_i = 1'b0;
    waitn(4);
    chk("R5 oe idle read", bus_oe_o, {DW{1'b1}});
    chk("R7 bus reset result", bus_o, 0);

    // R6 deselected
    sel_n_i = 1'b1;
    waitn(4);
    chk("R6 oe deselect", bus_oe_o, 0);

    // R2 no start while deselected
    rdconv_i = 1'b0;
    waitn(4);
    chk("R2 no start sel high", starts_seen, 0);
    rdconv_i = 1'b1;
    waitn(4);
    sel_n_i = 1'b0;
    hibyte_i = 1'b1;
    waitn(4);
    rdconv_i = 1'b0;
    waitn(4);
    chk("R2 no start hib high", starts_seen, 0);
    chk("R2 busy stays high", busy_o, 1);
    hibyte_i = 1'b0;
    rdconv_i = 1'b1;
    waitn(4);

    // R9 latency of start from falling edge
    rdconv_i = 1'b0;
    waitn(2);
    chk("R9 start not before third edge", start_o, 0);
    waitn(1);
    chk("R9 start on third edge", start_o, 1);
    chk("R9 busy low with start", busy_o, 0);
    waitn(1);
    chk("R2 start single cycle", start_o, 0);

    // R3 host activity during conversion is swallowed
    for (int i = 0; i < 6; i++) begin
      rdconv_i = 1'b1;
      waitn(3);
      chk("R5 oe off in conversion", bus_oe_o, 0);
      sel_n_i  = (i % 2 == 1);
      hibyte_i = (i == 3);
      waitn(3);
      sel_n_i  = 1'b0;
      hibyte_i = 1'b0;
      waitn(3);
      rdconv_i = 1'b0;
      waitn(4);
    end
    chk("R3 no extra start", starts_seen, 1);
    chk("R3 busy held low", busy_o, 0);

    // R4 done releases busy and latches result
    rdconv_i = 1'b1;
    waitn(4);
    pulse_done(12'hA5C);
    chk("R4 busy high after done", busy_o, 1);
    chk("R5 oe after done", bus_oe_o, {DW{1'b1}});
    chk("R7 bus word", bus_o, 12'hA5C);

    // R4 done while idle ignored
    pulse_done(12'h3C1);
    waitn(2);
    chk("R4 idle done ignored", bus_o, 12'hA5C);

    // R8 byte mode
    hibyte_i = 1'b1;
    waitn(4);
    chk("R8 byte mode bus", bus_o, 12'hA0A);
    chk("R8 byte mode oe", bus_oe_o, {DW{1'b1}});
    hibyte_i = 1'b0;
    waitn(4);

    // read mode: falling edge starts and blanks the bus
    rdconv_i = 1'b0;
    waitn(3);
    chk("R2 read mode start", starts_seen, 2);
    chk("R5 oe off after read pulse", bus_oe_o, 0);
    pulse_done(12'h5F0);
    exp_res = 12'h5F0;
    waitn(2);

    // random single-signal steps with automatic sequencer
    auto_eng   = 1'b1;
    conv_len   = 5;
    exp_starts = starts_seen;
    cur_sel = 1'b0;
    cur_rc  = 1'b0;
    cur_hib = 1'b0;
    for (int s = 0; s < 300; s++) begin
      int which;
      which = int'($urandom % 3);
      if (which == 0) begin
        cur_sel = ~cur_sel;
      end else if (which == 1) begin
        cur_hib = ~cur_hib;
      end else begin
        if (cur_rc && !cur_sel && !cur_hib) exp_starts++;
        cur_rc = ~cur_rc;
      end
      sel_n_i  = cur_sel;
      hibyte_i = cur_hib;
      rdconv_i = cur_rc;
      waitn(14);
      chk("R2 start count", starts_seen, exp_starts);
      chk("R4 idle after conversion", busy_o, 1);
      chk("R5 R6 oe", bus_oe_o, exp_oe(cur_rc, cur_sel));
      if (bus_oe_o == {DW{1'b1}})
        chk("R7 R8 bus", bus_o, exp_bus(exp_res, cur_hib));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule